// File: doc/BRIEF.md
# RGB to CMYK Pixel Converter

This block turns one pixel of three unsigned 8-bit light intensities (red, green, blue) into four unsigned 8-bit ink amounts for a printer: cyan, magenta, yellow and black. Each ink is first taken as the complement of its light channel against full scale. The black amount is the smallest of the three complements, which is the grey part that all three coloured inks share. That black amount is then removed from each coloured ink, so that the grey is laid down with black ink and less coloured ink is used.

A pixel enters with a valid strobe. The four results and a matching valid leave the block one clock later from a single output register stage. The output registers load only on cycles that carry a valid pixel, so the last result stays on the outputs between pixels.

Top module: `rgb2cmyk_conv`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid and all four ink outputs are cleared to zero at that edge.
- R2: out_valid equals the in_valid seen at the previous rising edge, one cycle of latency with no gaps or repeats.
- R3: out_k equals the minimum of 255-in_r, 255-in_g and 255-in_b for the pixel captured one cycle earlier.
- R4: out_c, out_m and out_y equal (255-in_r)-K, (255-in_g)-K and (255-in_b)-K, where K is the value on out_k; none of these wraps below zero.
- R5: For every valid output at least one of out_c, out_m and out_y is zero.
- R6: An input of (255,255,255) gives outputs (0,0,0,0) for (out_c,out_m,out_y,out_k).
- R7: An input of (0,0,0) gives outputs (0,0,0,255).
- R8: An input whose complements are (250,200,200), i.e. RGB (5,55,55), gives outputs (50,0,0,200); when two complements tie for the minimum the result is the same whichever is chosen.
- R9: A cycle with in_valid low leaves all four ink outputs unchanged at the next edge.

Top module port order below is the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel is present this cycle |
| in_r | input | 8 | Red intensity |
| in_g | input | 8 | Green intensity |
| in_b | input | 8 | Blue intensity |
| out_valid | output | 1 | Ink outputs carry a new result |
| out_c | output | 8 | Cyan after black removal |
| out_m | output | 8 | Magenta after black removal |
| out_y | output | 8 | Yellow after black removal |
| out_k | output | 8 | Black amount |

## Verification
The hardest case to reach is a tie for the minimum, where two or all three complements are equal and the comparator chain must still pick a channel whose removed value is zero; random pixels almost never produce it. The stimulus forces ties by copying one random channel onto another (and onto all three), and also drives the extremes 0 and 255 per channel. Gaps in in_valid are mixed in so that the hold behaviour of the output register is observed between pixels.

// File: rtl/cmyk_pkg.sv
// Package: shared types for the RGB to CMYK converter.
// Assumes: three ink channels, indexed cyan, magenta, yellow in that order.
package cmyk_pkg;
    localparam int NUM_INK = 3;

    // Which coloured ink supplied the minimum (the black amount).
    typedef enum logic [1:0] {
        PICK_C = 2'd0,
        PICK_M = 2'd1,
        PICK_Y = 2'd2
    } ink_pick_e;
endpackage

// File: rtl/ink_invert.sv
// Module: ink_invert
// Turns one light intensity into its ink amount, full scale minus input.
// Assumes: unsigned inputs; full scale is all ones so the result never wraps.
module ink_invert #(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0] light,
    output logic [CH_W-1:0] ink
);
    localparam logic [CH_W-1:0] FULL = '1;

    // Complement against full scale.
    always_comb begin
        ink = FULL - light;
    end
endmodule

// File: rtl/min3_select.sv
// Module: min3_select
// Finds the smallest of three ink amounts with two magnitude compares and
// two 2:1 muxes, and reports which channel won. Ties go to the lower index.
// Assumes: unsigned operands of equal width.
module min3_select
    import cmyk_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0] ink_a,
    input  logic [CH_W-1:0] ink_b,
    input  logic [CH_W-1:0] ink_c,
    output logic [CH_W-1:0] min_val,
    output ink_pick_e       min_src
);
    logic            a_le_b;
    logic [CH_W-1:0] ab_val;
    ink_pick_e       ab_src;
    logic            ab_le_c;

    // First stage: pick the smaller of channels a and b.
    always_comb begin
        a_le_b = (ink_a <= ink_b);
        ab_val = a_le_b ? ink_a : ink_b;
        ab_src = a_le_b ? PICK_C : PICK_M;
    end

    // Second stage: compare the first-stage winner with channel c.
    always_comb begin
        ab_le_c = (ab_val <= ink_c);
        min_val = ab_le_c ? ab_val : ink_c;
        min_src = ab_le_c ? ab_src : PICK_Y;
    end

    // Result never exceeds any operand (R3).
    always_comb begin
        if (!$isunknown({ink_a, ink_b, ink_c, min_val})) begin
            assert_min_bound_R3: assert (min_val <= ink_a && min_val <= ink_b && min_val <= ink_c)
                else $error("min3_select result above an operand");
        end
    end
endmodule

// File: rtl/grey_remove.sv
// Module: grey_remove
// Removes the shared black amount from one coloured ink.
// Assumes: grey is the minimum over all inks, so grey <= ink always holds.
module grey_remove #(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0] ink,
    input  logic [CH_W-1:0] grey,
    output logic [CH_W-1:0] rest
);
    // Plain subtraction; no saturation because the operand order is guaranteed.
    always_comb begin
        rest = ink - grey;
    end

    // The subtraction never wraps (R4).
    always_comb begin
        if (!$isunknown({ink, grey, rest})) begin
            assert_no_wrap_R4: assert (rest <= ink)
                else $error("grey_remove wrapped below zero");
        end
    end
endmodule

// File: rtl/rgb2cmyk_conv.sv
// Module: rgb2cmyk_conv
// Converts an RGB pixel to cyan, magenta, yellow with the grey part moved
// to black. Combinational invert -> min -> subtract, then one register stage.
// Assumes: synchronous active-low reset; data registers load only on in_valid.
module rgb2cmyk_conv
    import cmyk_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CH_W-1:0] in_r,
    input  logic [CH_W-1:0] in_g,
    input  logic [CH_W-1:0] in_b,
    output logic            out_valid,
    output logic [CH_W-1:0] out_c,
    output logic [CH_W-1:0] out_m,
    output logic [CH_W-1:0] out_y,
    output logic [CH_W-1:0] out_k
);
    localparam logic [CH_W:0] FULL_W = {1'b0, {CH_W{1'b1}}};

    logic [NUM_INK-1:0][CH_W-1:0] light;
    logic [NUM_INK-1:0][CH_W-1:0] ink;
    logic [NUM_INK-1:0][CH_W-1:0] rest;
    logic [CH_W-1:0]              black;
    ink_pick_e                    black_src;

    // Gather the light channels in ink order.
    always_comb begin
        light[0] = in_r;
        light[1] = in_g;
        light[2] = in_b;
    end

    // One complement unit per channel.
    for (genvar ch = 0; ch < NUM_INK; ch++) begin : g_inv
        ink_invert #(.CH_W(CH_W)) u_inv (
            .light (light[ch]),
            .ink   (ink[ch])
        );
    end

    min3_select #(.CH_W(CH_W)) u_min (
        .ink_a   (ink[0]),
        .ink_b   (ink[1]),
        .ink_c   (ink[2]),
        .min_val (black),
        .min_src (black_src)
    );

    // One grey-removal subtractor per channel.
    for (genvar ch = 0; ch < NUM_INK; ch++) begin : g_rem
        grey_remove #(.CH_W(CH_W)) u_rem (
            .ink  (ink[ch]),
            .grey (black),
            .rest (rest[ch])
        );
    end

    // Valid pipeline flag, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Output data register, loads only with a valid pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_c <= '0;
            out_m <= '0;
            out_y <= '0;
            out_k <= '0;
        end else if (in_valid) begin
            out_c <= rest[0];
            out_m <= rest[1];
            out_y <= rest[2];
            out_k <= black;
        end
    end

    // The channel that supplied the black amount ends at zero (R5).
    assert_pick_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (rest[int'(black_src)] == '0));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_out_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_c == '0 || out_m == '0 || out_y == '0));

    assert_sum_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (({1'b0, out_c} + {1'b0, out_k}) <= FULL_W &&
                       ({1'b0, out_m} + {1'b0, out_k}) <= FULL_W &&
                       ({1'b0, out_y} + {1'b0, out_k}) <= FULL_W));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({out_c, out_m, out_y, out_k}));
endmodule

// File: tb/tb_rgb2cmyk_conv.sv
module tb_rgb2cmyk_conv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [7:0] out_c, out_m, out_y, out_k;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state, updated behaviourally at each rising edge.
    int  e_valid = 0, e_c = 0, e_m = 0, e_y = 0, e_k = 0;
    bit  prev_in_valid = 1'b0;

    always #10 clk = ~clk;

    rgb2cmyk_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_c(out_c), .out_m(out_m),
        .out_y(out_y), .out_k(out_k)
    );

    function automatic int max3(int a, int b, int c);
        int m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    always @(posedge clk) begin
        prev_in_valid <= in_valid;
        if (!rst_n) begin
            e_valid <= 0; e_c <= 0; e_m <= 0; e_y <= 0; e_k <= 0;
        end else begin
            e_valid <= int'(in_valid);
            if (in_valid) begin
                int mx;
                mx = max3(int'(in_r), int'(in_g), int'(in_b));
                e_k <= 255 - mx;
                e_c <= mx - int'(in_r);
                e_m <= mx - int'(in_g);
                e_y <= mx - int'(in_b);
            end
        end
    endfunction_dummy_guard: begin end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every output against the model (called at a falling edge).
    task automatic compare_all();
        string tag;
        tag = prev_in_valid ? "R4" : "R9";
        chk("R2 out_valid", int'(out_valid), e_valid);
        chk("R3 out_k", int'(out_k), e_k);
        chk({tag, " out_c"}, int'(out_c), e_c);
        chk({tag, " out_m"}, int'(out_m), e_m);
        chk({tag, " out_y"}, int'(out_y), e_y);
        if (out_valid) chk("R5 one ink zero", int'(out_c == 0 || out_m == 0 || out_y == 0), 1);
    endtask

    task automatic step(bit v, int r, int g, int b);
        @(negedge clk);
        if (rst_n) compare_all();
        in_valid = v;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    endtask

    // Literal check of the result of the pixel driven by the previous step.
    task automatic lit(string req, int c, int m, int y, int k);
        @(negedge clk);
        chk({req, " c"}, int'(out_c), c);
        chk({req, " m"}, int'(out_m), m);
        chk({req, " y"}, int'(out_y), y);
        chk({req, " k"}, int'(out_k), k);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_k", int'(out_k), 0);
        chk("R1 out_c", int'(out_c), 0);
        rst_n = 1'b1;

        step(1, 255, 255, 255); lit("R6 white", 0, 0, 0, 0);
        step(1, 0, 0, 0);       lit("R7 black", 0, 0, 0, 255);
        step(1, 5, 55, 55);     lit("R8 tie", 50, 0, 0, 200);
        step(1, 100, 100, 40);  lit("R8 two-way tie", 0, 0, 60, 155);
        step(0, 9, 9, 9);       lit("R9 hold", 0, 0, 60, 155);

        for (int i = 0; i < 3000; i++) begin
            int r, g, b, mode;
            r = int'($urandom_range(0, 255));
            g = int'($urandom_range(0, 255));
            b = int'($urandom_range(0, 255));
            mode = int'($urandom_range(0, 7));
            case (mode)
                0: g = r;
                1: b = g;
                2: begin g = r; b = r; end
                3: r = 255;
                4: b = 0;
                default: ;
            endcase
            step(($urandom_range(0, 3) != 0), r, g, b);
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // Reset in mid-stream clears everything again (R1).
        step(1, 1, 2, 3);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 out_k after reset", int'(out_k), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule